// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out 32-bit atomic memory operations for one hart, using a single-ported synchronous memory. A request names an operation, a byte address and an operand. The block latches the request and reads the addressed word. It then applies the selected operator and writes the new word back. It returns the word that was in memory before the update, sign-extended to the register width. The core treats that value as the destination-register result.

The block also supports load-reserved and store-conditional. A load-reserved returns the word and arms a reservation on that word. A later store-conditional to the same word writes its operand and returns 0. If the reservation is gone or covers a different word, the store-conditional returns 1 and leaves memory alone. Three things drop the reservation:
- any store-conditional;
- an atomic request with a bad address or an unknown operation code;
- an ordinary store from the same hart to the reserved word, reported on a separate input.

Top module: `amo_unit`

## Requirements
- R1: Operation codes on `req_op` are: 0 load-reserved, 1 store-conditional, 2 swap, 3 add, 4 and, 5 or, 6 xor, 7 signed max, 8 unsigned max, 9 signed min, 10 unsigned min. For codes 2 to 10, `rsp_data` returns the pre-update memory word, sign-extended from bit 31. The new word is written back to the same address exactly once.
- R2: The new word is computed from the loaded word `m` and operand `b` (bits 31:0 of `req_wdata`) as follows:
  - swap gives `b`;
  - add gives `m+b` modulo 2^32;
  - and, or and xor give the bitwise result;
  - max and min compare `m` and `b` as two's-complement numbers for codes 7 and 9, and as unsigned numbers for codes 8 and 10.
- R3: Load-reserved returns the addressed word sign-extended, does not write memory, and arms a reservation on that word.
- R4: A store-conditional to the reserved word writes `b` there and returns 0.
- R5: A store-conditional fails, returning 1 with no memory write, in either case:
  - no reservation is armed;
  - the reservation covers a different word.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails.
- R7: An error response is given, with `rsp_err`=1 and `rsp_data`=0, for either of:
  - a request whose address bits 1:0 are not zero;
  - an operation code above 10.
  Such a request leaves memory unchanged and clears the reservation.
- R8: A pulse on `st_valid` whose `st_addr` falls in the reserved word clears the reservation. A store to another word does not.
- R9: Response timing is fixed per operation class:
  - `busy` is high from the cycle after acceptance until `rsp_valid` rises, and `rsp_valid` is a one-cycle pulse;
  - `rsp_valid` appears 4 clock edges after the accepting edge for codes 0 and 2 to 10;
  - it appears 2 edges after acceptance for store-conditional;
  - it appears 1 edge after acceptance for an error response.
- R10: A request presented while `busy` is high is ignored and produces no response and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 4 | Operation code (see R1) |
| req_addr | input | AW | Byte address |
| req_wdata | input | XLEN | Operand (low 32 bits used) |
| busy | output | 1 | Operation in progress |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | XLEN | Destination-register value |
| rsp_err | output | 1 | Bad address or unknown operation |
| st_valid | input | 1 | Ordinary store from the same hart |
| st_addr | input | AW | Byte address of that store |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after an enabled read |

## Verification
A reservation flag stuck high, or holding the wrong word, would surface at the next store-conditional. That store-conditional would return 0 instead of 1, and the target word would change within two cycles of acceptance. A sequencer that lost its place would show at the ports in one of three ways: a missing or doubled `rsp_valid` pulse, a write strobe without an enable, or a latency different from 4, 2 or 1 edges. A corrupt operator or a wrong latch of the loaded word shows in the memory contents once the response arrives. It also shows in the returned pre-update value.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    OP_LR   = 4'd0,
    OP_SC   = 4'd1,
    OP_SWAP = 4'd2,
    OP_ADD  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_MAX  = 4'd7,
    OP_MAXU = 4'd8,
    OP_MIN  = 4'd9,
    OP_MINU = 4'd10
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } amo_state_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] result
);
  logic lt_s, lt_u;

  always_comb begin
    lt_s = $signed(mem_val) < $signed(opnd);
    lt_u = mem_val < opnd;
    case (op)
      OP_SWAP: result = opnd;
      OP_ADD:  result = mem_val + opnd;
      OP_AND:  result = mem_val & opnd;
      OP_OR:   result = mem_val | opnd;
      OP_XOR:  result = mem_val ^ opnd;
      OP_MAX:  result = lt_s ? opnd : mem_val;
      OP_MAXU: result = lt_u ? opnd : mem_val;
      OP_MIN:  result = lt_s ? mem_val : opnd;
      OP_MINU: result = lt_u ? mem_val : opnd;
      default: result = mem_val;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int WA = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic [WA-1:0] set_addr,
  input  logic          clr,
  input  logic          snoop,
  input  logic [WA-1:0] snoop_addr,
  input  logic [WA-1:0] query_addr,
  output logic          hit
);
  logic          valid_q;
  logic [WA-1:0] addr_q;
  logic          snoop_kill;

  // A snoop that hits the word being armed in the same cycle wins.
  assign snoop_kill = snoop && (snoop_addr == (set ? set_addr : addr_q));
  assign hit        = valid_q && (addr_q == query_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (clr || snoop_kill) begin
      valid_q <= 1'b0;
    end else if (set) begin
      valid_q <= 1'b1;
      addr_q  <= set_addr;
    end
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [3:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [XLEN-1:0] req_wdata,
  output logic            busy,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data,
  output logic            rsp_err,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-3:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata
);
  localparam int WA = AW - 2;

  amo_state_e      state;
  logic [3:0]      op_q;
  logic [WA-1:0]   addr_q;
  logic [31:0]     opnd_q;
  logic            busy_q, rsp_valid_q, rsp_err_q;
  logic [XLEN-1:0] rsp_data_q;
  logic            mem_en_q, mem_we_q;
  logic [WA-1:0]   mem_addr_q;
  logic [31:0]     mem_wdata_q;

  logic            accept, bad_req, is_sc, sc_ok;
  logic [31:0]     alu_res;
  logic [WA-1:0]   req_word;

  assign req_word = req_addr[AW-1:2];
  assign accept   = req_valid && (state == ST_IDLE || state == ST_DONE);
  assign bad_req  = (req_addr[1:0] != 2'b00) || (req_op > 4'(OP_MINU));
  assign is_sc    = (req_op == 4'(OP_SC));

  amo_alu #(.DW(32)) alu_i (
    .op(op_q), .mem_val(mem_rdata), .opnd(opnd_q), .result(alu_res)
  );

  amo_resv #(.WA(WA)) resv_i (
    .clk(clk), .rst(rst),
    .set(state == ST_MODIFY && op_q == 4'(OP_LR)),
    .set_addr(addr_q),
    .clr(accept && (is_sc || bad_req)),
    .snoop(st_valid), .snoop_addr(st_addr[AW-1:2]),
    .query_addr(req_word),
    .hit(sc_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= '0;
      addr_q      <= '0;
      opnd_q      <= '0;
      busy_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
      mem_en_q    <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            op_q      <= req_op;
            addr_q    <= req_word;
            opnd_q    <= req_wdata[31:0];
            rsp_err_q <= 1'b0;
            if (bad_req) begin
              state       <= ST_DONE;
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= 1'b1;
              rsp_data_q  <= '0;
            end else if (is_sc) begin
              state       <= ST_WRITE;
              busy_q      <= 1'b1;
              mem_en_q    <= sc_ok;
              mem_we_q    <= sc_ok;
              mem_addr_q  <= req_word;
              mem_wdata_q <= req_wdata[31:0];
              rsp_data_q  <= sc_ok ? '0 : XLEN'(1);
            end else begin
              state      <= ST_READ;
              busy_q     <= 1'b1;
              mem_en_q   <= 1'b1;
              mem_we_q   <= 1'b0;
              mem_addr_q <= req_word;
            end
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_READ: begin
          mem_en_q <= 1'b0;
          state    <= ST_MODIFY;
        end
        ST_MODIFY: begin
          rsp_data_q  <= XLEN'($signed(mem_rdata));
          mem_en_q    <= (op_q != 4'(OP_LR));
          mem_we_q    <= (op_q != 4'(OP_LR));
          mem_wdata_q <= alu_res;
          state       <= ST_WRITE;
        end
        ST_WRITE: begin
          mem_en_q    <= 1'b0;
          mem_we_q    <= 1'b0;
          busy_q      <= 1'b0;
          rsp_valid_q <= 1'b1;
          state       <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_err   = rsp_err_q;
  assign mem_en    = mem_en_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [XLEN-1:0] rsp_data,
  input logic            mem_en,
  input logic            mem_we,
  input logic [3:0]      op
);
  p_busy_rsp_excl_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  p_busy_fall_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_valid);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid || !busy);

  p_err_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !mem_we);

  p_sc_result_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && op == 4'(OP_SC)) |-> (rsp_data <= XLEN'(1)));

  p_we_has_en_r1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  p_write_single_r1: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !rsp_valid) |-> !mem_we);
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_data(rsp_data), .mem_en(mem_en),
  .mem_we(mem_we), .op(op_q)
);

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
  localparam int XLEN = 32;
  localparam int AW   = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [3:0]      req_op = '0;
  logic [AW-1:0]   req_addr = '0;
  logic [XLEN-1:0] req_wdata = '0;
  logic            busy, rsp_valid, rsp_err;
  logic [XLEN-1:0] rsp_data;
  logic            st_valid = 1'b0;
  logic [AW-1:0]   st_addr = '0;
  logic            mem_en, mem_we;
  logic [AW-3:0]   mem_addr;
  logic [31:0]     mem_wdata;
  logic [31:0]     mem_rdata;

  logic [31:0] mem [0:255];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  amo_unit #(.XLEN(XLEN), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .st_valid(st_valid), .st_addr(st_addr), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] addr,
                       input logic [31:0] d, output logic [31:0] r,
                       output logic e, output int lat);
    bit busy_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      if (!busy) busy_bad = 1;
      @(negedge clk);
      lat++;
    end
    r = rsp_data; e = rsp_err;
    chk(!busy_bad, "R9 busy held until response", 64'(busy_bad), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !rsp_valid && !mem_en, "R9 reset idle",
        {busy, rsp_valid, mem_en}, 0);
  endtask

  task automatic t_amo(input logic [3:0] op, input logic [31:0] m,
                       input logic [31:0] b, input logic [31:0] exp_new,
                       input string tag);
    logic [31:0] r; logic e; int lat;
    @(negedge clk); mem[8] = m;
    issue(op, 16'h20, b, r, e, lat);
    chk(r == m && !e, {tag, " R1 old value"}, r, m);
    chk(mem[8] == exp_new, {tag, " R2 new value"}, mem[8], exp_new);
    chk(lat == 4, {tag, " R9 latency"}, lat, 4);
  endtask

  task automatic t_lr_sc();
    logic [31:0] r; logic e; int lat;
    @(negedge clk); mem[4] = 32'h8000_1234;
    issue(4'd0, 16'h10, 0, r, e, lat);
    chk(r == 32'h8000_1234, "R3 lr value", r, 32'h8000_1234);
    chk(mem[4] == 32'h8000_1234, "R3 lr no write", mem[4], 32'h8000_1234);
    issue(4'd1, 16'h10, 32'hCAFE_0001, r, e, lat);
    chk(r == 0, "R4 sc success returns 0", r, 0);
    chk(mem[4] == 32'hCAFE_0001, "R4 sc wrote", mem[4], 32'hCAFE_0001);
    chk(lat == 2, "R9 sc latency", lat, 2);
    issue(4'd1, 16'h10, 32'h5555_5555, r, e, lat);
    chk(r == 1, "R6 second sc fails", r, 1);
    chk(mem[4] == 32'hCAFE_0001, "R6 second sc no write", mem[4], 32'hCAFE_0001);
  endtask

  task automatic t_sc_other();
    logic [31:0] r; logic e; int lat;
    @(negedge clk); mem[5] = 32'h1111_1111; mem[6] = 32'h2222_2222;
    issue(4'd0, 16'h14, 0, r, e, lat);
    issue(4'd1, 16'h18, 32'h9999_9999, r, e, lat);
    chk(r == 1, "R5 sc wrong word fails", r, 1);
    chk(mem[6] == 32'h2222_2222, "R5 wrong word untouched", mem[6], 32'h2222_2222);
    issue(4'd1, 16'h14, 32'h9999_9999, r, e, lat);
    chk(r == 1, "R6 failed sc cleared reservation", r, 1);
    chk(mem[5] == 32'h1111_1111, "R5 no write", mem[5], 32'h1111_1111);
  endtask

  task automatic t_error();
    logic [31:0] r; logic e; int lat;
    @(negedge clk); mem[7] = 32'h7777_0000;
    issue(4'd0, 16'h1C, 0, r, e, lat);
    issue(4'd3, 16'h1D, 32'h1, r, e, lat);
    chk(e && r == 0, "R7 misaligned err", {e, r}, 64'h1_0000_0000);
    chk(lat == 1, "R9 error latency", lat, 1);
    chk(mem[7] == 32'h7777_0000, "R7 memory unchanged", mem[7], 32'h7777_0000);
    issue(4'd1, 16'h1C, 32'hAAAA_AAAA, r, e, lat);
    chk(r == 1 && mem[7] == 32'h7777_0000, "R7 reservation cleared", r, 1);
    issue(4'd12, 16'h1C, 32'h3, r, e, lat);
    chk(e && mem[7] == 32'h7777_0000, "R7 unknown op err", e, 1);
  endtask

  task automatic snoop(input logic [15:0] a);
    @(negedge clk); st_valid = 1'b1; st_addr = a;
    @(negedge clk); st_valid = 1'b0;
  endtask

  task automatic t_snoop();
    logic [31:0] r; logic e; int lat;
    issue(4'd0, 16'h24, 0, r, e, lat);
    snoop(16'h28);
    issue(4'd1, 16'h24, 32'h0BAD_F00D, r, e, lat);
    chk(r == 0 && mem[9] == 32'h0BAD_F00D, "R8 other-word store keeps reservation", r, 0);
    issue(4'd0, 16'h24, 0, r, e, lat);
    snoop(16'h26);
    issue(4'd1, 16'h24, 32'h1234_5678, r, e, lat);
    chk(r == 1 && mem[9] == 32'h0BAD_F00D, "R8 same-word store clears reservation", r, 1);
  endtask

  task automatic t_busy_ignore();
    int extra = 0;
    @(negedge clk); mem[10] = 32'h10; mem[11] = 32'h20;
    req_valid = 1'b1; req_op = 4'd2; req_addr = 16'h28; req_wdata = 32'h99;
    @(negedge clk);
    req_addr = 16'h2C; req_wdata = 32'h55;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rsp_valid) extra++;
    end
    chk(extra == 1, "R10 single response", extra, 1);
    chk(mem[11] == 32'h20, "R10 busy request ignored", mem[11], 32'h20);
    chk(mem[10] == 32'h99, "R10 first request done", mem[10], 32'h99);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_amo(4'd2,  32'h0000_0005, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "swap");
    t_amo(4'd3,  32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, "add");
    t_amo(4'd4,  32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, "and");
    t_amo(4'd5,  32'hF0F0_F0F0, 32'h0F00_0F00, 32'hFFF0_FFF0, "or");
    t_amo(4'd6,  32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA, "xor");
    t_amo(4'd7,  32'hFFFF_FFF0, 32'h0000_0003, 32'h0000_0003, "max");
    t_amo(4'd8,  32'hFFFF_FFF0, 32'h0000_0003, 32'hFFFF_FFF0, "maxu");
    t_amo(4'd9,  32'hFFFF_FFF0, 32'h0000_0003, 32'hFFFF_FFF0, "min");
    t_amo(4'd10, 32'hFFFF_FFF0, 32'h0000_0003, 32'h0000_0003, "minu");
    t_lr_sc();
    t_sc_other();
    t_error();
    t_snoop();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule